// File: doc/BRIEF.md
# Translation Buffer with Accessed/Dirty Assist

This block is a small, fully associative translation buffer that maps virtual page numbers to physical page numbers. Next to each translation it keeps a cached copy of the page's accessed and dirty flags and its write permission. A lookup gives one registered result on the following cycle: a hit with the physical page, a miss, or a permission fault. A miss tells the requester that an external page walker must supply the translation through the fill port before the access is retried.

The cached flags are not kept coherent with the page tables in memory. A hit whose cached accessed flag is clear, or a store whose cached dirty flag is clear, does not complete. Instead the block raises an update request so that the flag can be written back to memory. When the request is acknowledged, the block sets the cached flag and replays the stalled access as a hit. A flag that is already set in the buffer suppresses any further update, even if memory has since cleared it. Software resynchronizes the buffer with a flush of one page or a flush of all entries.

When the buffer is full, the entry to replace is chosen by a binary-tree pseudo-LRU. Empty slots are always used first.

Top module: `tlb_ad`

## Requirements
- R1: After reset no entry is valid, `req_ready` is 1, and `resp_valid` and `upd_req` are 0. A lookup of any page then misses.
- R2: A load that hits an entry whose cached flags need no update gives `resp_valid`=1 and `resp_hit`=1 with that entry's physical page on `resp_ppn`, one cycle after the request. At most one of `resp_hit`, `resp_miss` and `resp_fault` is set.
- R3: A lookup that matches no valid entry gives `resp_valid`=1 and `resp_miss`=1 one cycle later, with no update request.
- R4: A fill always sets the cached accessed flag. It sets the cached dirty flag only when `fill_store`=1. A store to an entry filled with `fill_store`=1 hits directly.
- R5: A store to a writable entry whose cached dirty flag is clear gives no response. On the next cycle it raises `upd_req` with `upd_vpn` set to the page and `upd_dirty`=1, and drops `req_ready`. `upd_req` holds with a stable page until `upd_ack` is 1.
- R6: On the cycle after `upd_ack`, `upd_req` falls and the stalled access completes as a hit with its physical page. The cached flag then stays set, so later stores to the page hit without an update until the entry is flushed.
- R7: A store to an entry filled with `fill_writable`=0 gives `resp_fault`=1 with neither a hit nor an update request. A load to that entry still hits.
- R8: `flush_all` makes every entry invalid from the next cycle on.
- R9: `flush_one` invalidates only the entry whose page equals `flush_vpn`. Other entries keep hitting.
- R10: A fill goes to the lowest-numbered empty slot. When no slot is empty, it replaces the pseudo-LRU victim. Filling slots 0 to 15 in order and then hitting slot 0 makes slot 8 the victim.
- R11: A request presented while `req_ready` is 0 is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_vpn | input | VPN_W | Virtual page to translate |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_ready | output | 1 | Block accepts lookups (low during an update assist) |
| resp_valid | output | 1 | Lookup result valid |
| resp_hit | output | 1 | Translation found, access completes |
| resp_miss | output | 1 | No translation, walk needed |
| resp_fault | output | 1 | Store to a page without write permission |
| resp_ppn | output | PPN_W | Physical page on a hit |
| upd_req | output | 1 | Request to write the accessed/dirty flags to memory |
| upd_vpn | output | VPN_W | Page whose flags need updating |
| upd_dirty | output | 1 | Update also sets the dirty flag |
| upd_ack | input | 1 | Flag update done |
| fill_valid | input | 1 | Walker delivers a translation |
| fill_vpn | input | VPN_W | Filled virtual page |
| fill_ppn | input | PPN_W | Filled physical page |
| fill_writable | input | 1 | Page allows stores |
| fill_store | input | 1 | Walk was caused by a store (fill dirty) |
| flush_all | input | 1 | Invalidate all entries |
| flush_one | input | 1 | Invalidate the entry for flush_vpn |
| flush_vpn | input | VPN_W | Page to invalidate |

## Verification
The checks assume that the walker never fills a page that is already held, so at most one entry matches any page. They also assume that fills, flushes and lookups never arrive in the same cycle, and that no fill or flush occurs while an update request is pending. The directed tasks drive one kind of operation per cycle, use distinct page numbers, flush before refilling a page, and send `upd_ack` only while `upd_req` is high. Within those limits, the assertions cover the update handshake, the replay, the exclusivity of results, whole-buffer invalidation and the pseudo-LRU moving its victim away from a touched slot.

// File: rtl/tlb_ad_pkg.sv
package tlb_ad_pkg;
  // control state: normal lookups, or stalled waiting for a flag update
  typedef enum logic {
    ST_RUN    = 1'b0,
    ST_ASSIST = 1'b1
  } tlb_state_e;

  // outcome of a lookup in the run state
  typedef enum logic [1:0] {
    LK_HIT    = 2'd0,
    LK_MISS   = 2'd1,
    LK_FAULT  = 2'd2,
    LK_ASSIST = 2'd3
  } lookup_e;
endpackage

// File: rtl/tlb_ad_match.sv
module tlb_ad_match #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]              key,
  output logic [ENTRIES-1:0]            match,
  output logic [IDX_W-1:0]              idx
);
  // parallel compare of all entries
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  // encode the matching slot (tags are unique among valid entries)
  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_ad_plru.sv
module tlb_ad_plru #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  // heap-ordered tree, node 1 is the root; a bit of 1 points right
  logic tree_q [1:ENTRIES-1];
  logic tree_d [1:ENTRIES-1];

  always_comb begin
    logic [IDX_W-1:0] nd;
    nd = IDX_W'(1);
    victim_idx = '0;
    for (int l = 0; l < IDX_W; l++) begin
      victim_idx[IDX_W-1-l] = tree_q[nd];
      nd = {nd[IDX_W-2:0], tree_q[nd]};
    end
  end

  always_comb begin
    logic [IDX_W-1:0] nd;
    tree_d = tree_q;
    nd = IDX_W'(1);
    if (touch_en) begin
      for (int l = 0; l < IDX_W; l++) begin
        tree_d[nd] = ~touch_idx[IDX_W-1-l];
        nd = {nd[IDX_W-2:0], touch_idx[IDX_W-1-l]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i < ENTRIES; i++) tree_q[i] <= 1'b0;
    end else begin
      tree_q <= tree_d;
    end
  end

  // a freshly touched slot is never the next victim
  assert_touch_away_R10: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> (victim_idx != $past(touch_idx)));
endmodule

// File: rtl/tlb_ad.sv
module tlb_ad
  import tlb_ad_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_store,
  output logic             req_ready,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_miss,
  output logic             resp_fault,
  output logic [PPN_W-1:0] resp_ppn,
  output logic             upd_req,
  output logic [VPN_W-1:0] upd_vpn,
  output logic             upd_dirty,
  input  logic             upd_ack,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_writable,
  input  logic             fill_store,
  input  logic             flush_all,
  input  logic             flush_one,
  input  logic [VPN_W-1:0] flush_vpn
);
  // entry storage
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0]            wr_q, acc_q, dirty_q;

  tlb_state_e       state_q;
  logic [IDX_W-1:0] sav_idx_q;

  // lookup and flush compares
  logic [ENTRIES-1:0] m_match, f_match;
  logic [IDX_W-1:0]   m_idx, f_idx;
  logic               m_hit;

  tlb_ad_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_lookup (
    .valid(valid_q), .tags(vpn_q), .key(req_vpn), .match(m_match), .idx(m_idx));
  tlb_ad_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_flush (
    .valid(valid_q), .tags(vpn_q), .key(flush_vpn), .match(f_match), .idx(f_idx));

  assign m_hit     = |m_match;
  assign req_ready = (state_q == ST_RUN);

  // classify the lookup: permission first, then the cached flags
  lookup_e lk;
  always_comb begin
    if (!m_hit)                                            lk = LK_MISS;
    else if (req_store && !wr_q[m_idx])                    lk = LK_FAULT;
    else if (!acc_q[m_idx] || (req_store && !dirty_q[m_idx])) lk = LK_ASSIST;
    else                                                   lk = LK_HIT;
  end

  // slot for a fill: lowest empty slot, else the pseudo-LRU victim
  logic [IDX_W-1:0] free_idx, victim_idx, fill_idx;
  logic             has_free;
  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_idx = IDX_W'(i);
        has_free = 1'b1;
      end
    end
  end
  assign fill_idx = has_free ? free_idx : victim_idx;

  logic             lookup_go, ack_go, touch_en;
  logic [IDX_W-1:0] touch_idx;
  assign lookup_go = (state_q == ST_RUN) && req_valid;
  assign ack_go    = (state_q == ST_ASSIST) && upd_ack;
  assign touch_en  = fill_valid || (lookup_go && m_hit);
  assign touch_idx = fill_valid ? fill_idx : m_idx;

  tlb_ad_plru #(.ENTRIES(ENTRIES)) u_plru (
    .clk(clk), .rst(rst), .touch_en(touch_en),
    .touch_idx(touch_idx), .victim_idx(victim_idx));

  // control, validity and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      sav_idx_q  <= '0;
      valid_q    <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_miss  <= 1'b0;
      resp_fault <= 1'b0;
      resp_ppn   <= '0;
      upd_req    <= 1'b0;
      upd_vpn    <= '0;
      upd_dirty  <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_miss  <= 1'b0;
      resp_fault <= 1'b0;
      if (lookup_go) begin
        case (lk)
          LK_HIT: begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_ppn   <= ppn_q[m_idx];
          end
          LK_MISS: begin
            resp_valid <= 1'b1;
            resp_miss  <= 1'b1;
          end
          LK_FAULT: begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b1;
          end
          default: begin
            state_q   <= ST_ASSIST;
            sav_idx_q <= m_idx;
            upd_req   <= 1'b1;
            upd_vpn   <= req_vpn;
            upd_dirty <= req_store;
          end
        endcase
      end
      if (ack_go) begin
        state_q    <= ST_RUN;
        upd_req    <= 1'b0;
        resp_valid <= 1'b1;
        resp_hit   <= 1'b1;
        resp_ppn   <= ppn_q[sav_idx_q];
      end
      if (flush_all) valid_q <= '0;
      else if (flush_one && |f_match) valid_q[f_idx] <= 1'b0;
      if (fill_valid) valid_q[fill_idx] <= 1'b1;
    end
  end

  // entry payload, no reset (gated by valid_q)
  always_ff @(posedge clk) begin
    if (fill_valid) begin
      vpn_q[fill_idx]   <= fill_vpn;
      ppn_q[fill_idx]   <= fill_ppn;
      wr_q[fill_idx]    <= fill_writable;
      acc_q[fill_idx]   <= 1'b1;
      dirty_q[fill_idx] <= fill_store;
    end
    if (ack_go) begin
      acc_q[sav_idx_q] <= 1'b1;
      if (upd_dirty) dirty_q[sav_idx_q] <= 1'b1;
    end
  end

  // R2: results are mutually exclusive
  assert_one_result_R2: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $onehot({resp_hit, resp_miss, resp_fault}));

  // R5: an update request holds with its page until acknowledged
  assert_upd_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_req && !upd_ack) |=> (upd_req && $stable(upd_vpn)));

  // R6: acknowledge replays the stalled access as a hit
  assert_replay_R6: assert property (@(posedge clk) disable iff (rst)
    (upd_req && upd_ack) |=> (resp_valid && resp_hit && !upd_req));

  // R8: flush of everything empties the buffer
  assert_flush_all_R8: assert property (@(posedge clk) disable iff (rst)
    (flush_all && !fill_valid) |=> (valid_q == '0));

  // R11: no result while the block is stalled
  assert_busy_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> !resp_valid);
endmodule

// File: tb/tlb_ad_tb.sv
module tlb_ad_tb;
  localparam int VPN_W = 20;
  localparam int PPN_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_store = 0, upd_ack = 0;
  logic [VPN_W-1:0] req_vpn = '0, fill_vpn = '0, flush_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic fill_valid = 0, fill_writable = 0, fill_store = 0;
  logic flush_all = 0, flush_one = 0;
  logic req_ready, resp_valid, resp_hit, resp_miss, resp_fault, upd_req, upd_dirty;
  logic [PPN_W-1:0] resp_ppn;
  logic [VPN_W-1:0] upd_vpn;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tlb_ad u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vpn(req_vpn),
    .req_store(req_store), .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_fault(resp_fault),
    .resp_ppn(resp_ppn), .upd_req(upd_req), .upd_vpn(upd_vpn),
    .upd_dirty(upd_dirty), .upd_ack(upd_ack), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_writable(fill_writable),
    .fill_store(fill_store), .flush_all(flush_all), .flush_one(flush_one),
    .flush_vpn(flush_vpn));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // present one lookup; on return the registered result is visible
  task automatic lookup(input logic [VPN_W-1:0] v, input logic st);
    @(negedge clk);
    req_valid = 1; req_vpn = v; req_store = st;
    @(negedge clk);
    req_valid = 0; req_store = 0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                      input logic wr, input logic st);
    @(negedge clk);
    fill_valid = 1; fill_vpn = v; fill_ppn = p; fill_writable = wr; fill_store = st;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic expect_hit(input string tag, input logic [PPN_W-1:0] p);
    chk(tag, {resp_valid, resp_hit, upd_req}, 3'b110);
    chk(tag, resp_ppn, p);
  endtask

  task automatic expect_miss(input string tag);
    chk(tag, {resp_valid, resp_miss, upd_req}, 3'b110);
  endtask

  task automatic ack_update;
    upd_ack = 1;
    @(negedge clk);
    upd_ack = 0;
  endtask

  task automatic t_reset;
    chk("R1 ready", req_ready, 1);
    chk("R1 idle outputs", {resp_valid, upd_req}, 0);
    lookup(20'h5, 0);
    expect_miss("R1 empty miss");
  endtask

  task automatic t_miss_fill_hit;
    lookup(20'h10, 0);
    expect_miss("R3 miss");
    chk("R3 no hit", {resp_hit, resp_fault}, 0);
    fill(20'h10, 16'h00A1, 1, 0);
    lookup(20'h10, 0);
    expect_hit("R2 load hit", 16'h00A1);
    chk("R2 single flag", {resp_miss, resp_fault}, 0);
  endtask

  task automatic t_store_fill;
    fill(20'h20, 16'h00B2, 1, 1);
    lookup(20'h20, 1);
    expect_hit("R4 store after store-fill", 16'h00B2);
  endtask

  task automatic t_assist;
    lookup(20'h10, 1);
    chk("R5 no response", resp_valid, 0);
    chk("R5 upd_req", upd_req, 1);
    chk("R5 upd_vpn", upd_vpn, 20'h10);
    chk("R5 upd_dirty", upd_dirty, 1);
    chk("R5 not ready", req_ready, 0);
    repeat (2) @(negedge clk);
    chk("R5 held", {upd_req, resp_valid}, 2'b10);
    ack_update();
    expect_hit("R6 replay", 16'h00A1);
    chk("R6 ready again", req_ready, 1);
    lookup(20'h10, 1);
    expect_hit("R6 dirty stays set", 16'h00A1);
  endtask

  task automatic t_busy;
    fill(20'h30, 16'h00C3, 1, 0);
    lookup(20'h30, 1);
    chk("R11 assist started", upd_req, 1);
    req_valid = 1; req_vpn = 20'h10; req_store = 0;
    @(negedge clk);
    req_valid = 0;
    chk("R11 ignored request", resp_valid, 0);
    ack_update();
    expect_hit("R11 replay is stalled store", 16'h00C3);
    @(negedge clk);
    chk("R11 no late response", resp_valid, 0);
  endtask

  task automatic t_fault;
    fill(20'h40, 16'h00D4, 0, 0);
    lookup(20'h40, 1);
    chk("R7 fault", {resp_valid, resp_fault, resp_hit, upd_req}, 4'b1100);
    lookup(20'h40, 0);
    expect_hit("R7 load still hits", 16'h00D4);
  endtask

  task automatic t_flush_one;
    @(negedge clk);
    flush_one = 1; flush_vpn = 20'h40;
    @(negedge clk);
    flush_one = 0;
    lookup(20'h40, 0);
    expect_miss("R9 flushed page misses");
    lookup(20'h10, 0);
    expect_hit("R9 other page kept", 16'h00A1);
    // resync: flush and refill clean, next store needs an update again
    @(negedge clk);
    flush_one = 1; flush_vpn = 20'h10;
    @(negedge clk);
    flush_one = 0;
    fill(20'h10, 16'h00A1, 1, 0);
    lookup(20'h10, 1);
    chk("R6 update after resync", {upd_req, resp_valid}, 2'b10);
    ack_update();
    expect_hit("R6 resync replay", 16'h00A1);
  endtask

  task automatic t_flush_all;
    @(negedge clk);
    flush_all = 1;
    @(negedge clk);
    flush_all = 0;
    lookup(20'h10, 0);
    expect_miss("R8 page 10");
    lookup(20'h20, 0);
    expect_miss("R8 page 20");
    lookup(20'h30, 0);
    expect_miss("R8 page 30");
  endtask

  task automatic t_plru;
    for (int i = 0; i < 16; i++) fill(20'h100 + 20'(i), 16'(i) + 16'h0100, 1, 0);
    lookup(20'h10F, 0);
    expect_hit("R10 slot 15 filled", 16'h010F);
    lookup(20'h100, 0);
    expect_hit("R10 slot 0", 16'h0100);
    fill(20'h200, 16'h0055, 1, 0);
    lookup(20'h108, 0);
    expect_miss("R10 victim slot 8 evicted");
    lookup(20'h100, 0);
    expect_hit("R10 touched slot kept", 16'h0100);
    lookup(20'h200, 0);
    expect_hit("R10 new page", 16'h0055);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_miss_fill_hit();
    t_store_fill();
    t_assist();
    t_busy();
    t_fault();
    t_flush_one();
    t_flush_all();
    t_plru();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule